// File: doc/BRIEF.md
# Periodic Bus Refresh Stall Injector

This block keeps the timing books of a 16-bit processor bus whose memory needs a refresh at a fixed interval. It holds a running master-cycle count and a refresh mark. Each time the processor has fetched an opcode, the surrounding model pulses a fetch strobe. If one whole refresh period has gone by since the mark, the block charges a short bus stall, moves the mark onto the period grid and raises a one-cycle stall request. It then adds the cost of the instruction that follows.

An instruction that runs for a full period or longer, or one flagged as absorbing, pushes the mark forward by one period, so one refresh penalty is dropped. A processor reset charges its exception cost and lines the mark up with the grid without a stall. At the end of a video frame the frame length is taken off both counters, so the distance between them is kept.

Top module: `refresh_stall_injector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, `cyc_o` and `ref_o` are 0, `stall_o` is 0 and `stall_len_o` is 0.
- R2: A `fetch_i` cycle raises `stall_o` on the next cycle when `cyc_o - ref_o` before that strobe is at least 896, which is the period of 128 processor cycles at 7 master cycles each. At 895 or less there is no stall.
- R3: When a stall is triggered, the new mark is the pre-strobe cycle count rounded down to a multiple of 896.
- R4: A triggered stall adds 14 master cycles (2 processor cycles) to the count. `stall_len_o` reads 14 on the stall cycle and 0 on every other cycle.
- R5: Every `fetch_i` cycle adds `cost_i` to the cycle count, after the refresh check.
- R6: On a `fetch_i` cycle where `cost_i` is 896 or more or `skip_i` is high, the mark advances by 896 on top of any R3 update.
- R7: `cpu_rst_i` sets the count to its old value plus `cost_i` and the mark to that sum rounded down to a multiple of 896. It raises no stall, and it overrides `fetch_i` and `frame_i` in the same cycle.
- R8: `frame_i` subtracts `frame_len_i` from both the count and the mark, after any fetch effect in the same cycle. The mark may become negative, and later rounding floors toward minus infinity.
- R9: With no strobe high, both counters hold their values and `stall_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Opcode fetched; run the refresh check and charge `cost_i` |
| cost_i | input | 16 | Master-cycle cost of the instruction, or of the reset exception |
| skip_i | input | 1 | Instruction absorbs one refresh period |
| cpu_rst_i | input | 1 | Processor reset: charge `cost_i` and align the mark |
| frame_i | input | 1 | End of frame: rebase both counters |
| frame_len_i | input | 32 | Master-cycle length of the frame that ended |
| stall_o | output | 1 | One-cycle stall request |
| stall_len_o | output | 8 | Stall length in master cycles while `stall_o` is high, else 0 |
| cyc_o | output | 32 | Signed running master-cycle count |
| ref_o | output | 32 | Signed refresh mark |

## Verification
Both counters are on the ports, so a wrong mark or count shows up one cycle after the strobe that caused it. A bad rounding step first shows in `ref_o`, and it reaches `stall_o` only at a later fetch near the 896 threshold. The bench therefore compares every register on every step. It also steps through the 895/896 edge, negative marks after rebasing, and long instructions that absorb a refresh.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_FETCH  = 2'd1,
    OP_CPURST = 2'd2
  } rsi_op_e;
endpackage

// File: rtl/rsi_grid_snap.sv
module rsi_grid_snap #(
  parameter int CW     = 32,
  parameter int PERIOD = 896
) (
  input  logic signed [CW-1:0] val_i,
  output logic signed [CW-1:0] snap_o
);
  localparam logic signed [CW-1:0] P = CW'(PERIOD);

  logic signed [CW-1:0] quot, rem;

  always_comb begin
    quot = val_i / P;
    rem  = val_i - quot * P;
    if (rem < 0) quot = quot - 1;
    snap_o = quot * P;
  end

  always_comb begin
    if (!$isunknown(val_i)) begin
      assert_snap_floor_R3: assert (snap_o <= val_i && (val_i - snap_o) < P);
    end
  end
endmodule

// File: rtl/rsi_fetch_step.sv
module rsi_fetch_step #(
  parameter int CW     = 32,
  parameter int COSTW  = 16,
  parameter int PERIOD = 896,
  parameter int STALL  = 14
) (
  input  logic signed [CW-1:0] cyc_i,
  input  logic signed [CW-1:0] ref_i,
  input  logic [COSTW-1:0]     cost_i,
  input  logic                 skip_i,
  output logic                 trig_o,
  output logic signed [CW-1:0] cyc_nx_o,
  output logic signed [CW-1:0] ref_nx_o
);
  localparam logic signed [CW-1:0] P  = CW'(PERIOD);
  localparam logic signed [CW-1:0] ST = CW'(STALL);

  logic signed [CW-1:0] snapped, base_ref;
  logic                 absorb;

  rsi_grid_snap #(.CW(CW), .PERIOD(PERIOD)) u_snap (
    .val_i (cyc_i),
    .snap_o(snapped)
  );

  always_comb begin
    trig_o   = (cyc_i - ref_i) >= P;
    absorb   = skip_i || ({{(CW-COSTW){1'b0}}, cost_i} >= P);
    base_ref = trig_o ? snapped : ref_i;
    ref_nx_o = base_ref + (absorb ? P : '0);
    cyc_nx_o = cyc_i + (trig_o ? ST : '0) + CW'(cost_i);
  end
endmodule

// File: rtl/refresh_stall_injector.sv
module refresh_stall_injector #(
  parameter int CW          = 32,
  parameter int COSTW       = 16,
  parameter int LENW        = 8,
  parameter int CPU_DIV     = 7,
  parameter int REFRESH_CPU = 128,
  parameter int STALL_CPU   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_i,
  input  logic [COSTW-1:0]     cost_i,
  input  logic                 skip_i,
  input  logic                 cpu_rst_i,
  input  logic                 frame_i,
  input  logic [CW-1:0]        frame_len_i,
  output logic                 stall_o,
  output logic [LENW-1:0]      stall_len_o,
  output logic signed [CW-1:0] cyc_o,
  output logic signed [CW-1:0] ref_o
);
  import rsi_pkg::*;

  localparam int PERIOD = REFRESH_CPU * CPU_DIV;
  localparam int STALL  = STALL_CPU * CPU_DIV;

  logic signed [CW-1:0] cyc_q, ref_q;
  logic signed [CW-1:0] f_cyc, f_ref, r_cyc, r_snap;
  logic signed [CW-1:0] cyc_d, ref_d;
  logic                 trig;
  rsi_op_e              op;

  always_comb begin
    if (cpu_rst_i)    op = OP_CPURST;
    else if (fetch_i) op = OP_FETCH;
    else              op = OP_IDLE;
  end

  rsi_fetch_step #(.CW(CW), .COSTW(COSTW), .PERIOD(PERIOD), .STALL(STALL)) u_step (
    .cyc_i   (cyc_q),
    .ref_i   (ref_q),
    .cost_i  (cost_i),
    .skip_i  (skip_i),
    .trig_o  (trig),
    .cyc_nx_o(f_cyc),
    .ref_nx_o(f_ref)
  );

  assign r_cyc = cyc_q + CW'(cost_i);

  rsi_grid_snap #(.CW(CW), .PERIOD(PERIOD)) u_rst_snap (
    .val_i (r_cyc),
    .snap_o(r_snap)
  );

  always_comb begin
    cyc_d = cyc_q;
    ref_d = ref_q;
    unique case (op)
      OP_CPURST: begin cyc_d = r_cyc; ref_d = r_snap; end
      OP_FETCH:  begin cyc_d = f_cyc; ref_d = f_ref;  end
      default:   ;
    endcase
    if (frame_i && op != OP_CPURST) begin
      cyc_d = cyc_d - $signed(frame_len_i);
      ref_d = ref_d - $signed(frame_len_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q       <= '0;
      ref_q       <= '0;
      stall_o     <= 1'b0;
      stall_len_o <= '0;
    end else begin
      cyc_q       <= cyc_d;
      ref_q       <= ref_d;
      stall_o     <= (op == OP_FETCH) && trig;
      stall_len_o <= ((op == OP_FETCH) && trig) ? LENW'(STALL) : '0;
    end
  end

  assign cyc_o = cyc_q;
  assign ref_o = ref_q;

  assert_stall_len_R4: assert property (@(posedge clk) disable iff (rst)
    stall_o ? (stall_len_o == LENW'(STALL)) : (stall_len_o == '0));

  assert_stall_at_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $past(fetch_i && !cpu_rst_i));

  assert_reset_align_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_rst_i) |-> ((ref_q % CW'(PERIOD)) == 0 && !stall_o));

  assert_frame_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $past(frame_i && !fetch_i && !cpu_rst_i) |-> ((cyc_q - ref_q) == $past(cyc_q - ref_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!fetch_i && !cpu_rst_i && !frame_i) |-> ($stable(cyc_q) && $stable(ref_q) && !stall_o));
endmodule

// File: tb/refresh_stall_injector_bench.sv
module refresh_stall_injector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 896;
  localparam int ST = 14;

  logic clk = 0, rst = 1;
  logic fetch_i = 0, skip_i = 0, cpu_rst_i = 0, frame_i = 0;
  logic [15:0] cost_i = 0;
  logic [31:0] frame_len_i = 0;
  logic stall_o;
  logic [7:0] stall_len_o;
  logic signed [31:0] cyc_o, ref_o;

  int checks = 0, fails = 0;
  int m_cyc = 0, m_ref = 0, m_stall = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_stall_injector u_refresh_stall_injector (
    .clk(clk), .rst(rst), .fetch_i(fetch_i), .cost_i(cost_i), .skip_i(skip_i),
    .cpu_rst_i(cpu_rst_i), .frame_i(frame_i), .frame_len_i(frame_len_i),
    .stall_o(stall_o), .stall_len_o(stall_len_o), .cyc_o(cyc_o), .ref_o(ref_o));

  function automatic int floor_grid(int x);
    if (x >= 0) return (x / P) * P;
    return -(((-x) + P - 1) / P) * P;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " cyc"}, cyc_o, m_cyc);
    chk({req, " ref"}, ref_o, m_ref);
    chk({req, " stall"}, int'(stall_o), m_stall);
    chk({req, " len"}, int'(stall_len_o), m_stall ? ST : 0);
  endtask

  task automatic step(string req, bit f, int c, bit sk, bit cr, bit fr, int fl);
    fetch_i = f; cost_i = 16'(c); skip_i = sk; cpu_rst_i = cr;
    frame_i = fr; frame_len_i = 32'(fl);
    @(posedge clk); #1;
    m_stall = 0;
    if (cr) begin
      m_cyc = m_cyc + c;
      m_ref = floor_grid(m_cyc);
    end else begin
      if (f) begin
        if (m_cyc - m_ref >= P) begin
          m_ref = floor_grid(m_cyc);
          m_cyc += ST;
          m_stall = 1;
        end
        m_cyc += c;
        if (sk || c >= P) m_ref += P;
      end
      if (fr) begin m_cyc -= fl; m_ref -= fl; end
    end
    fetch_i = 0; skip_i = 0; cpu_rst_i = 0; frame_i = 0;
    compare_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    repeat (3) @(posedge clk);
    #1; compare_all("R1 in reset");
    rst = 0;
    @(posedge clk); #1; compare_all("R1 after reset");

    // R7: reset exception charge aligns mark, no stall
    step("R7 cpu reset", 0, 1000, 0, 1, 0, 0);
    step("R7 override", 1, 50, 0, 1, 1, 300);
    // R2 boundary: gap 895 then 896
    step("R5 fetch", 1, P + 895 - (m_cyc - m_ref) - P, 0, 0, 0, 0);
    step("R2 gap 895 no stall", 1, 1, 0, 0, 0, 0);
    step("R2 R3 R4 gap 896 stall", 1, 28, 0, 0, 0, 0);
    step("R9 idle", 0, 500, 1, 0, 0, 0);
    // R6 long instruction absorbs
    step("R6 long cost", 1, 900, 0, 0, 0, 0);
    step("R6 after long", 1, 7, 0, 0, 0, 0);
    step("R6 skip flag", 1, 70, 1, 0, 0, 0);
    // R8 push mark negative
    step("R8 frame", 0, 0, 0, 0, 1, m_ref + 500);
    step("R8 fetch+frame", 1, 700, 0, 0, 1, 1000);
    step("R3 negative floor", 1, 14, 0, 0, 0, 0);
    step("R3 negative floor 2", 1, 14, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      int c = 7 * (2 + $urandom % 40);
      if (r < 3) step("R6 rnd long", 1, P + $urandom % 400, 0, 0, 0, 0);
      else if (r < 5) step("R6 rnd skip", 1, c, 1, 0, 0, 0);
      else if (r < 7) step("R9 rnd idle", 0, c, 0, 0, 0, 0);
      else if (r < 8) step("R7 rnd cpu reset", $urandom % 2, c, 0, 1, 1, 77);
      else if (m_cyc > 60000) step("R8 rnd frame", $urandom % 2, c, 0, 0, 1, 59000 + $urandom % 2000);
      else step("R2 R5 rnd fetch", 1, c, 0, 0, 0, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule